// File: doc/BRIEF.md
# Indirect Extended Register Window

This block is the register front end of a host-side peripheral whose four select lines are all taken by a legacy register map. It adds two command registers (called extension A and extension B here) and a read-only status register without changing any legacy select code. They are reached through one legacy code.

Bit 7 of the primary command register (select code 0110) is the window enable. While it is clear, select code 1010 keeps its legacy register. While it is set, code 1010 opens a window. The window reaches the register chosen by the index held in the address register (select code 0000): index 0x00 is the status register, 0x01 is extension A and 0x02 is extension B.

The status register reports the following:
- a busy flag and a sense flag, both taken from inputs;
- a fixed revision field;
- whether the last address load was for reading or writing;
- which color component (red, green, blue) the next data-port access will use.

All accesses are one clock long. Read data is registered.

Top module: `xreg_window`

## Requirements
- R1: After reset, every register (primary command, address, legacy 1010, extension A, extension B, read/write mode, component) is zero, and the read-data output is zero.
- R2: Writes to select code 0110 (primary command) and select code 0000 (address) are returned unchanged by reads of the same code.
- R3: With bit 7 of the primary command register clear, select code 1010 reads and writes the legacy register, and extension A and B are left untouched.
- R4: With bit 7 set, select code 1010 reads and writes extension A for index 0x01 and extension B for index 0x02, and the legacy register is left untouched.
- R5: With bit 7 set and index 0x00, select code 1010 reads the status byte {0, busyIn, REV[1:0], senseIn, mode, comp[1:0]}, where bit 7 is 0 and REV defaults to 00.
- R6: The status mode bit (bit 2) becomes 0 after a write to select code 0000 or 0100, and 1 after a write to select code 0011 or 0111. No other access changes it.
- R7: Status bits 1:0 (00 red, 01 green, 10 blue) become 00 after a write to select code 0000, 0011, 0100 or 0111. Each read or write of select code 0001 or 0101 steps them 00→01→10→00.
- R8: With bit 7 set and an index from 0x03 to 0xFF, the window reads as zero and writes change no register.
- R9: A write through the window at index 0x00 changes nothing that the status byte reports.
- R10: Read data appears on the clock edge that samples rdStb and holds until the next read. When wrStb and rdStb are both high, only the write takes place and the read data holds.
- R11: A reset applied after writes returns extension A and the primary command register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 4 | Register select code |
| wrData | input | 8 | Write data |
| wrStb | input | 1 | Write strobe, one access per cycle high |
| rdStb | input | 1 | Read strobe, one access per cycle high |
| busyIn | input | 1 | Busy flag reported in status bit 6 |
| senseIn | input | 1 | Sense flag reported in status bit 3 |
| rdData | output | 8 | Registered read data |

## Verification
Every write takes effect at the rising edge that samples wrStb, and every read result appears on rdData right after the rising edge that samples rdStb. Each result is therefore due exactly one edge after its strobe. The bench drives sel, data and strobes at the falling edge and waits for the next rising edge. It samples rdData at the falling edge after that, so each check reads a value that has had half a cycle to settle. Status reads show busyIn and senseIn as they were at that same sampling edge.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam logic [3:0] SEL_ADDR   = 4'h0;
  localparam logic [3:0] SEL_DATA_P = 4'h1;
  localparam logic [3:0] SEL_RDADDR = 4'h3;
  localparam logic [3:0] SEL_WRAUX  = 4'h4;
  localparam logic [3:0] SEL_DATA_A = 4'h5;
  localparam logic [3:0] SEL_CMD0   = 4'h6;
  localparam logic [3:0] SEL_RDAUX  = 4'h7;
  localparam logic [3:0] SEL_WIN    = 4'hA;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CMD0, RD_ADDR, RD_LEGACY, RD_STATUS, RD_EXTA, RD_EXTB
  } rdSrc_e;

  typedef struct packed {
    logic   wrCmd0;
    logic   wrAddr;
    logic   wrLegacy;
    logic   wrExtA;
    logic   wrExtB;
    logic   modeLoad;
    logic   modeVal;
    logic   compClr;
    logic   compStep;
    logic   rdEn;
    rdSrc_e rdSrc;
  } xStrobe_t;
endpackage

// File: rtl/xreg_ctrl.sv
module xreg_ctrl
  import xreg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        sel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic              extEn,
  input  logic [DATA_W-1:0] idx,
  output xStrobe_t          strb
);
  rdSrc_e src;
  logic   doWr;
  logic   doRd;

  always_comb begin
    doWr = wrStb;
    doRd = rdStb && !wrStb;
    case (sel)
      SEL_CMD0: src = RD_CMD0;
      SEL_ADDR: src = RD_ADDR;
      SEL_WIN: begin
        if (!extEn)                 src = RD_LEGACY;
        else if (idx == DATA_W'(0)) src = RD_STATUS;
        else if (idx == DATA_W'(1)) src = RD_EXTA;
        else if (idx == DATA_W'(2)) src = RD_EXTB;
        else                        src = RD_ZERO;
      end
      default: src = RD_ZERO;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.rdSrc    = src;
    strb.rdEn     = doRd;
    strb.wrCmd0   = doWr && (src == RD_CMD0);
    strb.wrAddr   = doWr && (src == RD_ADDR);
    strb.wrLegacy = doWr && (src == RD_LEGACY);
    strb.wrExtA   = doWr && (src == RD_EXTA);
    strb.wrExtB   = doWr && (src == RD_EXTB);
    if (doWr && (sel == SEL_ADDR || sel == SEL_WRAUX)) begin
      strb.modeLoad = 1'b1;
      strb.modeVal  = 1'b0;
      strb.compClr  = 1'b1;
    end else if (doWr && (sel == SEL_RDADDR || sel == SEL_RDAUX)) begin
      strb.modeLoad = 1'b1;
      strb.modeVal  = 1'b1;
      strb.compClr  = 1'b1;
    end
    strb.compStep = (doWr || doRd) && (sel == SEL_DATA_P || sel == SEL_DATA_A);
  end

  // R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCmd0, strb.wrAddr, strb.wrLegacy, strb.wrExtA, strb.wrExtB}));

  // R3
  legacy_noext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel == SEL_WIN && !extEn) |-> !(strb.wrExtA || strb.wrExtB));

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> !strb.rdEn);
endmodule

// File: rtl/xreg_datapath.sv
module xreg_datapath
  import xreg_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter logic [1:0] REV    = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  xStrobe_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busyIn,
  input  logic              senseIn,
  output logic              extEn,
  output logic [DATA_W-1:0] idx,
  output logic [DATA_W-1:0] rdData
);
  localparam int ENABLE_BIT = DATA_W - 1;
  localparam logic [1:0] COMP_LAST = 2'd2;

  logic [DATA_W-1:0] cmd0Q, addrQ, legacyQ, extAQ, extBQ, rdDataQ, rdMux;
  logic              modeQ;
  logic [1:0]        compQ;
  logic [7:0]        statusByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd0Q   <= '0;
      addrQ   <= '0;
      legacyQ <= '0;
      extAQ   <= '0;
      extBQ   <= '0;
      modeQ   <= 1'b0;
      compQ   <= 2'd0;
      rdDataQ <= '0;
    end else begin
      if (strb.wrCmd0)   cmd0Q   <= wrData;
      if (strb.wrAddr)   addrQ   <= wrData;
      if (strb.wrLegacy) legacyQ <= wrData;
      if (strb.wrExtA)   extAQ   <= wrData;
      if (strb.wrExtB)   extBQ   <= wrData;
      if (strb.modeLoad) modeQ   <= strb.modeVal;
      if (strb.compClr)       compQ <= 2'd0;
      else if (strb.compStep) compQ <= (compQ == COMP_LAST) ? 2'd0 : compQ + 2'd1;
      if (strb.rdEn)     rdDataQ <= rdMux;
    end
  end

  always_comb begin
    statusByte = {1'b0, busyIn, REV, senseIn, modeQ, compQ};
    case (strb.rdSrc)
      RD_CMD0:   rdMux = cmd0Q;
      RD_ADDR:   rdMux = addrQ;
      RD_LEGACY: rdMux = legacyQ;
      RD_STATUS: rdMux = DATA_W'(statusByte);
      RD_EXTA:   rdMux = extAQ;
      RD_EXTB:   rdMux = extBQ;
      default:   rdMux = '0;
    endcase
  end

  assign extEn  = cmd0Q[ENABLE_BIT];
  assign idx    = addrQ;
  assign rdData = rdDataQ;

  // R7
  comp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    compQ != 2'b11);

  // R7
  comp_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.compClr |=> compQ == 2'd0);

  // R6
  mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeLoad |=> modeQ == $past(strb.modeVal));

  // R8
  exta_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrExtA |=> $stable(extAQ));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdDataQ));
endmodule

// File: rtl/xreg_window.sv
module xreg_window
  import xreg_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter logic [1:0] REV    = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        sel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic              busyIn,
  input  logic              senseIn,
  output logic [DATA_W-1:0] rdData
);
  xStrobe_t          strb;
  logic              extEn;
  logic [DATA_W-1:0] idx;

  xreg_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sel(sel), .wrStb(wrStb), .rdStb(rdStb),
    .extEn(extEn), .idx(idx), .strb(strb)
  );

  xreg_datapath #(.DATA_W(DATA_W), .REV(REV)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .busyIn(busyIn), .senseIn(senseIn),
    .extEn(extEn), .idx(idx), .rdData(rdData)
  );
endmodule

// File: tb/tb_xreg_window.sv
`timescale 1ns/1ps
module tb_xreg_window;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] sel = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic       busyIn = 1'b0;
  logic       senseIn = 1'b0;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic       mdl_mode;
  logic [1:0] mdl_comp;

  always #2.5 clk = ~clk;

  xreg_window dut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrData(wrData), .wrStb(wrStb),
    .rdStb(rdStb), .busyIn(busyIn), .senseIn(senseIn), .rdData(rdData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wrData = d; wrStb = 1'b1; rdStb = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] v);
    @(negedge clk);
    sel = s; rdStb = 1'b1; wrStb = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rdStb = 1'b0;
    v = rdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [7:0] expStatus(logic b, logic s, logic m, logic [1:0] c);
    return {1'b0, b, 2'b00, s, m, c};
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdData after reset", rdData, 8'h00);
    rd(4'h6, v); chk("R1 cmd0 reset", v, 8'h00);
    rd(4'h0, v); chk("R1 addr reset", v, 8'h00);
    rd(4'hA, v); chk("R1 legacy reset", v, 8'h00);

    // R2: address register full sweep, primary command sample with bit 7 clear
    for (int i = 0; i < 256; i++) begin
      wr(4'h0, 8'(i)); rd(4'h0, v); chk("R2 addr readback", v, 8'(i));
    end
    for (int i = 0; i < 128; i += 17) begin
      wr(4'h6, 8'(i)); rd(4'h6, v); chk("R2 cmd0 readback", v, 8'(i));
    end

    // R3: legacy register with window disabled
    wr(4'h6, 8'h00);
    wr(4'hA, 8'h5A); rd(4'hA, v); chk("R3 legacy readback", v, 8'h5A);
    wr(4'h6, 8'h80); wr(4'h0, 8'h01);
    rd(4'hA, v); chk("R3 extA untouched", v, 8'h00);

    // R4: extension A sweep, extension B, legacy untouched
    for (int i = 0; i < 256; i++) begin
      wr(4'hA, 8'(i)); rd(4'hA, v); chk("R4 extA readback", v, 8'(i));
    end
    wr(4'h0, 8'h02); wr(4'hA, 8'hC3); rd(4'hA, v); chk("R4 extB readback", v, 8'hC3);
    wr(4'h0, 8'h01); rd(4'hA, v); chk("R4 extA kept", v, 8'hFF);
    wr(4'h6, 8'h00); rd(4'hA, v); chk("R4 legacy untouched", v, 8'h5A);

    // R8: unused indices
    wr(4'h6, 8'h80);
    for (int i = 3; i < 256; i++) begin
      wr(4'h0, 8'(i)); wr(4'hA, 8'hEE); rd(4'hA, v); chk("R8 unused index zero", v, 8'h00);
    end
    wr(4'h0, 8'h01); rd(4'hA, v); chk("R8 extA unchanged", v, 8'hFF);
    wr(4'h0, 8'h02); rd(4'hA, v); chk("R8 extB unchanged", v, 8'hC3);
    wr(4'h6, 8'h00); rd(4'hA, v); chk("R8 legacy unchanged", v, 8'h5A);
    wr(4'h6, 8'h80);

    // R5: status with all busy/sense combinations
    wr(4'h0, 8'h00);
    mdl_mode = 1'b0; mdl_comp = 2'd0;
    for (int i = 0; i < 4; i++) begin
      busyIn = i[1]; senseIn = i[0];
      rd(4'hA, v); chk("R5 status byte", v, expStatus(i[1], i[0], 1'b0, 2'd0));
    end

    // R6 R7: write sweep then read sweep over select codes
    busyIn = 1'b1; senseIn = 1'b1;
    for (int c = 0; c < 16; c++) begin
      if (c == 6 || c == 10) continue;
      wr(4'(c), 8'h00);
      if (c == 0 || c == 4) begin mdl_mode = 1'b0; mdl_comp = 2'd0; end
      else if (c == 3 || c == 7) begin mdl_mode = 1'b1; mdl_comp = 2'd0; end
      else if (c == 1 || c == 5) mdl_comp = (mdl_comp == 2'd2) ? 2'd0 : mdl_comp + 2'd1;
      rd(4'hA, v); chk("R6 R7 status after write", v, expStatus(1'b1, 1'b1, mdl_mode, mdl_comp));
    end
    for (int c = 0; c < 16; c++) begin
      if (c == 10) continue;
      rd(4'(c), v);
      if (c == 1 || c == 5) mdl_comp = (mdl_comp == 2'd2) ? 2'd0 : mdl_comp + 2'd1;
      rd(4'hA, v); chk("R6 R7 status after read", v, expStatus(1'b1, 1'b1, mdl_mode, mdl_comp));
    end
    wr(4'h3, 8'h00); mdl_mode = 1'b1; mdl_comp = 2'd0;
    for (int k = 0; k < 7; k++) begin
      wr(4'h1, 8'h11);
      mdl_comp = (mdl_comp == 2'd2) ? 2'd0 : mdl_comp + 2'd1;
      rd(4'hA, v); chk("R7 component wrap", v, expStatus(1'b1, 1'b1, mdl_mode, mdl_comp));
    end

    // R9: writes to status ignored
    wr(4'hA, 8'hFF);
    rd(4'hA, v); chk("R9 status write ignored", v, expStatus(1'b1, 1'b1, mdl_mode, mdl_comp));
    wr(4'hA, 8'h00);
    rd(4'hA, v); chk("R9 status write ignored", v, expStatus(1'b1, 1'b1, mdl_mode, mdl_comp));

    // R10: read data hold and write priority
    rd(4'h6, held); chk("R10 cmd0 read", held, 8'h80);
    repeat (3) @(negedge clk);
    chk("R10 rdData holds idle", rdData, 8'h80);
    @(negedge clk);
    sel = 4'h0; wrData = 8'h01; wrStb = 1'b1; rdStb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0;
    chk("R10 rdData holds on write+read", rdData, 8'h80);
    rd(4'h0, v); chk("R10 write taken", v, 8'h01);

    // R11: reset after writes
    wr(4'hA, 8'h3C); rd(4'hA, v); chk("R11 extA before reset", v, 8'h3C);
    doReset();
    rd(4'h6, v); chk("R11 cmd0 cleared", v, 8'h00);
    wr(4'h6, 8'h80); wr(4'h0, 8'h01);
    rd(4'hA, v); chk("R11 extA cleared", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule